// File: doc/BRIEF.md
# Time-Shared Peripheral Processor Barrel

This block runs a set of small peripheral processors, twelve by default, on a single shared execution datapath. A slot counter gives each processor one clock in turn. The processor whose slot is current is the only one whose program counter, accumulator, channel number or mode can change on that edge. One full turn of the barrel therefore gives every processor exactly one step. With a 100 ns slot, that is one step per processor every 1.2 µs at twelve processors.

The block also carries the start-up path. A deadstart pulse, or reset, puts every processor on the I/O channel whose number matches its own index. Processor 0 enters a load mode in which it copies each word presented on its channel into successive locations of its private memory, starting at address 0. When that channel signals disconnect while holding no word, processor 0 switches to running its program from address 1. The other processors wait on their channels, and nothing in this block wakes them. The instruction set is limited to a handful of load, add and jump operations.

The outputs show the slot index and the state of the processor in the current slot, as it stands before that slot's step.

Top module: `pp_barrel`

## Requirements
- R1: The slot index counts 0,1,...,NPROC-1, advances by one each clock, and wraps from NPROC-1 to 0. A clock edge with deadstart high makes the next slot 0.
- R2: Reset or deadstart sets every processor's pc and accumulator to 0 and its channel to its own index. Processor 0 enters load mode and all others enter wait mode. Deadstart keeps memory contents; reset clears memory to zero.
- R3: In processor 0's slot, load mode with its channel full stores the channel word at memory address pc and increments pc. During that cycle, chan_take raises only the bit of that channel.
- R4: In load mode, an empty channel without disconnect leaves all state unchanged, and the load retries on the next turn. A full channel that also signals disconnect stores the word, and the disconnect takes effect on a later turn.
- R5: In load mode, disconnect on an empty channel switches to run mode with pc=1. The accumulator is left unchanged.
- R6: An instruction word holds the opcode in bits 11:6 and a field d in bits 5:0. Opcode 0 and all opcodes above 6 only increment pc. Opcode 2 sets pc=pc+d if the accumulator is zero, and pc=pc+1 otherwise.
- R7: Opcode 1 sets pc=pc+d modulo the memory depth and leaves all 18 accumulator bits unchanged.
- R8: Opcode 3 writes d zero-extended to all 18 accumulator bits, so bits 17:6 become zero.
- R9: Opcode 4 adds d, and opcode 6 adds the 12-bit word at memory address d, to the accumulator modulo 2^18. Opcode 5 loads that word zero-extended. Each of these opcodes then increments pc.
- R10: A processor in wait mode ignores its channel inputs: its state stays unchanged and no chan_take bit rises.
- R11: cur_pc, cur_acc, cur_mode and cur_chan show the state of the processor named by cur_slot before that slot's step. cur_mode is encoded as 0 for wait, 1 for load and 2 for run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deadstart | input | 1 | Synchronous start-up pulse |
| ch_data | input | NPROC*12 | Channel words, channel i at bits 12i+11:12i |
| ch_full | input | NPROC | Channel i holds a word |
| ch_disc | input | NPROC | Channel i signals disconnect |
| chan_take | output | NPROC | Channel i word consumed at this edge |
| cur_slot | output | clog2(NPROC) | Current slot index |
| cur_mode | output | 2 | Mode of the served processor |
| cur_pc | output | clog2(DEPTH) | Program counter of the served processor |
| cur_acc | output | 18 | Accumulator of the served processor |
| cur_chan | output | clog2(NPROC) | Channel number of the served processor |

## Verification
The assertions assume that deadstart is a synchronous level sampled at the clock and that reset is held for at least one edge. They assume nothing about the channel lines, which may change freely in every slot. The stimulus therefore drives random full, disconnect and data values on every channel in every cycle, including the channels of waiting processors. Channel 0 follows a feed schedule with random gaps, and its last word sometimes arrives together with disconnect. Deadstart is raised at a random slot.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  localparam int WORD_W = 12;
  localparam int ACC_W  = 18;
  localparam int OP_W   = 6;
  localparam int FLD_W  = WORD_W - OP_W;

  typedef enum logic [1:0] {
    PM_WAIT = 2'd0,
    PM_LOAD = 2'd1,
    PM_RUN  = 2'd2
  } pmode_t;

  localparam logic [OP_W-1:0] OP_NOP  = 6'd0;
  localparam logic [OP_W-1:0] OP_JMPF = 6'd1;
  localparam logic [OP_W-1:0] OP_ZJMP = 6'd2;
  localparam logic [OP_W-1:0] OP_LDK  = 6'd3;
  localparam logic [OP_W-1:0] OP_ADK  = 6'd4;
  localparam logic [OP_W-1:0] OP_LDM  = 6'd5;
  localparam logic [OP_W-1:0] OP_ADM  = 6'd6;

  function automatic logic [OP_W-1:0] word_op(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:FLD_W];
  endfunction

  function automatic logic [FLD_W-1:0] word_fld(input logic [WORD_W-1:0] w);
    return w[FLD_W-1:0];
  endfunction

  // 12-bit adder input widened into the 18-bit accumulator
  function automatic logic [ACC_W-1:0] acc_plus(input logic [ACC_W-1:0] a,
                                                input logic [WORD_W-1:0] v);
    return a + ACC_W'(v);
  endfunction
endpackage

// File: rtl/barrel_slot_ctr.sv
module barrel_slot_ctr #(
  parameter int NPROC = 12,
  localparam int SW = $clog2(NPROC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deadstart,
  output logic [SW-1:0] slot
);
  localparam logic [SW-1:0] LAST = SW'(NPROC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || deadstart) slot <= '0;
    else if (slot == LAST)   slot <= '0;
    else                     slot <= slot + SW'(1);
  end

  a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!deadstart && slot != LAST) |=> slot == $past(slot) + SW'(1));
  a_r1_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!deadstart && slot == LAST) |=> slot == '0);
  a_r1_deadstart_slot: assert property (@(posedge clk) disable iff (!rst_n)
    deadstart |=> slot == '0);
endmodule

// File: rtl/barrel_pp_mem.sv
module barrel_pp_mem
  import barrel_pkg::*;
#(
  parameter int NPROC = 12,
  parameter int DEPTH = 64,
  localparam int SW = $clog2(NPROC),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SW-1:0]     proc,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     iaddr,
  output logic [WORD_W-1:0] iword,
  input  logic [AW-1:0]     oaddr,
  output logic [WORD_W-1:0] oword
);
  logic [WORD_W-1:0] mem_q [NPROC][DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPROC; p++)
        for (int a = 0; a < DEPTH; a++)
          mem_q[p][a] <= '0;
    end else if (we) begin
      mem_q[proc][waddr] <= wdata;
    end
  end

  assign iword = mem_q[proc][iaddr];
  assign oword = mem_q[proc][oaddr];
endmodule

// File: rtl/barrel_pp_regs.sv
module barrel_pp_regs
  import barrel_pkg::*;
#(
  parameter int NPROC = 12,
  parameter int DEPTH = 64,
  localparam int SW = $clog2(NPROC),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deadstart,
  input  logic [SW-1:0]     slot,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] opnd,
  input  logic              sel_full,
  input  logic              sel_disc,
  output logic [AW-1:0]     opnd_addr,
  output logic              load_we,
  output pmode_t            cur_mode,
  output logic [AW-1:0]     cur_pc,
  output logic [ACC_W-1:0]  cur_acc,
  output logic [SW-1:0]     cur_chan
);
  pmode_t            mode_q [NPROC];
  logic [AW-1:0]     pc_q   [NPROC];
  logic [ACC_W-1:0]  acc_q  [NPROC];
  logic [SW-1:0]     chan_q [NPROC];

  pmode_t            nx_mode;
  logic [AW-1:0]     nx_pc;
  logic [ACC_W-1:0]  nx_acc;
  logic [OP_W-1:0]   op;
  logic [FLD_W-1:0]  fld;
  // named events for the checks below
  logic ev_jump, ev_ldk, ev_boot;

  assign cur_mode  = mode_q[slot];
  assign cur_pc    = pc_q[slot];
  assign cur_acc   = acc_q[slot];
  assign cur_chan  = chan_q[slot];
  assign op        = word_op(instr);
  assign fld       = word_fld(instr);
  assign opnd_addr = AW'(fld);

  always_comb begin
    nx_mode = cur_mode;
    nx_pc   = cur_pc;
    nx_acc  = cur_acc;
    load_we = 1'b0;
    ev_jump = 1'b0;
    ev_ldk  = 1'b0;
    ev_boot = 1'b0;
    case (cur_mode)
      PM_LOAD: begin
        if (sel_full) begin
          load_we = 1'b1;
          nx_pc   = cur_pc + AW'(1);
        end else if (sel_disc) begin
          nx_mode = PM_RUN;
          nx_pc   = AW'(1);
          ev_boot = 1'b1;
        end
      end
      PM_RUN: begin
        nx_pc = cur_pc + AW'(1);
        case (op)
          OP_JMPF: begin
            nx_pc   = cur_pc + AW'(fld);
            ev_jump = 1'b1;
          end
          OP_ZJMP: if (cur_acc == '0) nx_pc = cur_pc + AW'(fld);
          OP_LDK: begin
            nx_acc = ACC_W'(fld);
            ev_ldk = 1'b1;
          end
          OP_ADK:  nx_acc = acc_plus(cur_acc, WORD_W'(fld));
          OP_LDM:  nx_acc = ACC_W'(opnd);
          OP_ADM:  nx_acc = acc_plus(cur_acc, opnd);
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || deadstart) begin
      for (int i = 0; i < NPROC; i++) begin
        mode_q[i] <= (i == 0) ? PM_LOAD : PM_WAIT;
        pc_q[i]   <= '0;
        acc_q[i]  <= '0;
        chan_q[i] <= SW'(i);
      end
    end else begin
      mode_q[slot] <= nx_mode;
      pc_q[slot]   <= nx_pc;
      acc_q[slot]  <= nx_acc;
    end
  end

  a_r2_deadstart_state: assert property (@(posedge clk) disable iff (!rst_n)
    deadstart |=> (mode_q[0] == PM_LOAD && pc_q[0] == '0 && acc_q[0] == '0));
  a_r3_load_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (load_we && !deadstart) |=> pc_q[$past(slot)] == $past(cur_pc) + AW'(1));
  a_r5_disc_boots: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_boot && !deadstart) |=> (mode_q[$past(slot)] == PM_RUN &&
                                 pc_q[$past(slot)] == AW'(1)));
  a_r7_jump_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_jump && !deadstart) |=> acc_q[$past(slot)] == $past(cur_acc));
  a_r8_ldk_clears_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ldk && !deadstart) |=> acc_q[$past(slot)][ACC_W-1:FLD_W] == '0);
  a_r10_wait_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == PM_WAIT && !deadstart) |=>
      (pc_q[$past(slot)] == $past(cur_pc) && acc_q[$past(slot)] == $past(cur_acc) &&
       mode_q[$past(slot)] == PM_WAIT));
endmodule

// File: rtl/pp_barrel.sv
module pp_barrel
  import barrel_pkg::*;
#(
  parameter int NPROC = 12,
  parameter int DEPTH = 64,
  localparam int SW = $clog2(NPROC),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    deadstart,
  input  logic [NPROC*WORD_W-1:0] ch_data,
  input  logic [NPROC-1:0]        ch_full,
  input  logic [NPROC-1:0]        ch_disc,
  output logic [NPROC-1:0]        chan_take,
  output logic [SW-1:0]           cur_slot,
  output logic [1:0]              cur_mode,
  output logic [AW-1:0]           cur_pc,
  output logic [ACC_W-1:0]        cur_acc,
  output logic [SW-1:0]           cur_chan
);
  logic [SW-1:0]     slot;
  logic [WORD_W-1:0] instr, opnd, sel_word;
  logic              sel_full, sel_disc, load_we, wr_en;
  logic [AW-1:0]     opnd_addr;
  pmode_t            mode_w;

  barrel_slot_ctr #(.NPROC(NPROC)) u_slot (
    .clk(clk), .rst_n(rst_n), .deadstart(deadstart), .slot(slot)
  );

  // channel selected by the served processor
  always_comb begin
    sel_word = '0;
    sel_full = 1'b0;
    sel_disc = 1'b0;
    for (int i = 0; i < NPROC; i++) begin
      if (cur_chan == SW'(i)) begin
        sel_word = ch_data[i*WORD_W +: WORD_W];
        sel_full = ch_full[i];
        sel_disc = ch_disc[i];
      end
    end
  end

  barrel_pp_regs #(.NPROC(NPROC), .DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .deadstart(deadstart), .slot(slot),
    .instr(instr), .opnd(opnd), .sel_full(sel_full), .sel_disc(sel_disc),
    .opnd_addr(opnd_addr), .load_we(load_we), .cur_mode(mode_w),
    .cur_pc(cur_pc), .cur_acc(cur_acc), .cur_chan(cur_chan)
  );

  assign wr_en = load_we && !deadstart;

  barrel_pp_mem #(.NPROC(NPROC), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .proc(slot),
    .waddr(cur_pc), .wdata(sel_word),
    .iaddr(cur_pc), .iword(instr), .oaddr(opnd_addr), .oword(opnd)
  );

  generate
    for (genvar g = 0; g < NPROC; g++) begin : g_take
      assign chan_take[g] = wr_en && (cur_chan == SW'(g));
    end
  endgenerate

  assign cur_slot = slot;
  assign cur_mode = mode_w;

  a_r3_take_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_take));
  a_r10_no_take_unless_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w != PM_LOAD) |-> chan_take == '0);
endmodule

// File: tb/test_pp_barrel.sv
module test_pp_barrel;
  localparam int NP = 12;
  localparam int DP = 64;

  logic           clk = 1'b0;
  logic           rst_n, deadstart;
  logic [NP*12-1:0] ch_data;
  logic [NP-1:0]  ch_full, ch_disc, chan_take;
  logic [3:0]     cur_slot, cur_chan;
  logic [1:0]     cur_mode;
  logic [5:0]     cur_pc;
  logic [17:0]    cur_acc;

  pp_barrel #(.NPROC(NP), .DEPTH(DP)) i_pp_barrel (
    .clk(clk), .rst_n(rst_n), .deadstart(deadstart), .ch_data(ch_data),
    .ch_full(ch_full), .ch_disc(ch_disc), .chan_take(chan_take),
    .cur_slot(cur_slot), .cur_mode(cur_mode), .cur_pc(cur_pc),
    .cur_acc(cur_acc), .cur_chan(cur_chan)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // bench model of processor 0
  logic [11:0] bm [DP];
  logic [1:0]  m_mode;
  logic [5:0]  m_pc;
  logic [17:0] m_acc;
  int          exp_slot;
  string       last_tag;

  logic [11:0] feed [DP];
  int          feed_len, feed_idx, gap_pct;
  bit          overlap;

  function automatic logic [11:0] mk(input int op, input int d);
    return {6'(op), 6'(d)};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_exec();
    logic [11:0] w;
    logic [5:0]  op, d;
    w  = bm[m_pc];
    op = w[11:6];
    d  = w[5:0];
    case (op)
      6'd1: begin m_pc = m_pc + d; last_tag = "R7"; end
      6'd2: begin m_pc = (m_acc == 18'd0) ? m_pc + d : m_pc + 6'd1; last_tag = "R6"; end
      6'd3: begin m_acc = {12'd0, d}; m_pc++; last_tag = "R8"; end
      6'd4: begin m_acc = m_acc + {12'd0, d}; m_pc++; last_tag = "R9"; end
      6'd5: begin m_acc = {6'd0, bm[d]}; m_pc++; last_tag = "R9"; end
      6'd6: begin m_acc = m_acc + {6'd0, bm[d]}; m_pc++; last_tag = "R9"; end
      default: begin m_pc++; last_tag = "R6"; end
    endcase
  endtask

  task automatic one_cycle(input bit ds);
    bit f0, d0;
    logic [11:0] w0;
    // observe state of the served processor (R11)
    chk("R1", "slot", cur_slot, exp_slot);
    chk("R11", "chan", cur_chan, exp_slot);
    if (exp_slot == 0) begin
      chk(last_tag, "mode0", cur_mode, m_mode);
      chk(last_tag, "pc0", cur_pc, m_pc);
      chk(last_tag, "acc0", cur_acc, m_acc);
    end else begin
      chk("R10", "waiting mode", cur_mode, 0);
      chk("R10", "waiting pc", cur_pc, 0);
      chk("R10", "waiting acc", cur_acc, 0);
    end
    // random traffic on every channel, waiting ones included
    for (int i = 0; i < NP; i++) ch_data[i*12 +: 12] = 12'($urandom);
    ch_full = NP'($urandom);
    ch_disc = NP'($urandom);
    f0 = ch_full[0]; d0 = ch_disc[0]; w0 = ch_data[11:0];
    if (exp_slot == 0 && m_mode == 2'd1 && !ds) begin
      if (feed_idx < feed_len) begin
        if (int'($urandom % 100) < gap_pct) begin f0 = 0; d0 = 0; end
        else begin
          f0 = 1; w0 = feed[feed_idx];
          d0 = overlap && (feed_idx == feed_len - 1);
        end
      end else begin f0 = 0; d0 = 1; end
    end
    ch_full[0] = f0; ch_disc[0] = d0; ch_data[11:0] = w0;
    deadstart = ds;
    #1;
    chk((exp_slot == 0) ? "R3" : "R10", "chan_take", chan_take,
        (exp_slot == 0 && m_mode == 2'd1 && f0 && !ds) ? 1 : 0);
    if (ds) begin
      m_mode = 2'd1; m_pc = 0; m_acc = 0; last_tag = "R2";
      exp_slot = 0;
    end else begin
      if (exp_slot == 0) begin
        if (m_mode == 2'd1) begin
          if (f0) begin bm[m_pc] = w0; m_pc++; feed_idx++; last_tag = "R3"; end
          else if (d0) begin m_mode = 2'd2; m_pc = 6'd1; last_tag = "R5"; end
          else last_tag = "R4";
        end else if (m_mode == 2'd2) model_exec();
      end
      exp_slot = (exp_slot == NP - 1) ? 0 : exp_slot + 1;
    end
    @(negedge clk);
  endtask

  task automatic run_round(input int turns);
    int target;
    target = int'($urandom % NP);
    while (exp_slot != target) one_cycle(1'b0);
    feed_idx = 0;
    one_cycle(1'b1);
    for (int k = 0; k < 4000 && m_mode != 2'd2; k++) one_cycle(1'b0);
    chk("R5", "booted", m_mode, 2);
    repeat (turns * NP) one_cycle(1'b0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; deadstart = 0; ch_data = '0; ch_full = '0; ch_disc = '0;
    for (int a = 0; a < DP; a++) bm[a] = 12'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R2", "reset slot", cur_slot, 0);
    chk("R2", "reset mode0", cur_mode, 1);
    chk("R2", "reset pc0", cur_pc, 0);
    chk("R2", "reset acc0", cur_acc, 0);
    chk("R2", "reset take", chan_take, 0);
    @(negedge clk);
    // the first edge after reset is an ordinary slot-0 step with idle channels
    m_mode = 2'd1; m_pc = 0; m_acc = 0; exp_slot = 1; last_tag = "R2";
    feed_len = 0; feed_idx = 0; gap_pct = 0; overlap = 0;
    // directed program: 18-bit carry, jump keeps acc, load-constant clears
    feed[0]  = 12'hFFF;        feed[1]  = mk(3, 63);
    feed[2]  = mk(6, 0);       feed[3]  = mk(1, 2);
    feed[4]  = mk(3, 5);       feed[5]  = mk(6, 0);
    feed[6]  = mk(2, 3);       feed[7]  = mk(3, 0);
    feed[8]  = mk(2, 2);       feed[9]  = mk(4, 1);
    feed[10] = mk(4, 7);       feed[11] = mk(5, 0);
    feed[12] = mk(1, 0);
    feed_len = 13; gap_pct = 0; overlap = 1;
    run_round(20);
    chk("R9", "directed final acc", m_acc, 18'hFFF);
    // R2: memory survives deadstart; short feed runs into older words
    feed[0] = 12'h001; feed_len = 1; gap_pct = 50; overlap = 0;
    run_round(16);
    // random programs with gaps
    for (int r = 0; r < 8; r++) begin
      feed_len = 4 + int'($urandom % 20);
      for (int i = 0; i < feed_len; i++)
        feed[i] = mk(int'($urandom % 8), int'($urandom % 64));
      gap_pct = 30; overlap = bit'($urandom % 2);
      run_round(30);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule